// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Generator

This block sits after a basic E1 framer in the transmit path. It takes the serial bit stream one bit per enable strobe and groups frames into a 16-frame multiframe. The multiframe is split into two 8-frame halves, here called half I (frames 0 to 7) and half II (frames 8 to 15). The block overwrites only the first bit of each frame, which is the international bit of timeslot 0. Every other bit passes through unchanged, and the output appears one clock after the input.

The international bits carry three kinds of content:
- Odd frames 1 to 11 carry the fixed alignment word 001011.
- The even frames of each half carry the 4-bit CRC of the half sent just before.
- Odd frames 13 and 15 carry the two far-end error bits.

The error bits have three sources: pending receive-error events, two static control bits, or the input stream left as it is. Two request inputs each invert one item a single time. One inverts the next whole alignment word. The other inverts the four CRC bits of the next half.

A small three-state controller handles each one-shot inversion. Its states are Idle, Armed and Active. Idle moves to Armed when a request arrives. Armed moves to Active at the first slot of the target window. Active returns to Idle after the last slot of that window.

Top module: `e1_crc4_mfgen`

## Requirements
- R1: The position counters advance only on `bit_en`. `dout_vld` is `bit_en` delayed by one clock. Each non-international bit appears on `dout` one clock after it was presented on `din`. `mf_mark` is high with the output of bit 0 of frame 0.
- R2: Bit 0 of frames 1, 3, 5, 7, 9 and 11 carries 0, 0, 1, 0, 1, 1 in that frame order.
- R3: Bit 0 of frames 0, 2, 4 and 6 of a half carries C1, C2, C3 and C4 of the previous half, in that order. The CRC uses x^4+x+1 with a zero start value. C1 is the x^3 coefficient. It is computed MSB-first over all 8*BITS_PER_FRAME output bits of that half, with its CRC positions taken as 0.
- R4: Until the first half after reset is complete, every CRC position is sent as 1.
- R5: E1 is bit 0 of frame 13 and reports half I. E2 is bit 0 of frame 15 and reports half II.
- R6: With `febe_en`=1, an E bit is 0 if its error input pulsed since that E bit's previous slot, and 1 otherwise. Each slot clears its pending event. An event in the slot's own cycle is reported at the next slot.
- R7: With `febe_en`=0 and `si_dis`=0, E1 is `si_val[1]` and E2 is `si_val[0]`.
- R8: With `febe_en`=0 and `si_dis`=1, the E positions pass `din` unchanged.
- R9: One `inv_align_req` pulse, given outside an alignment window, inverts all six bits of the next alignment word that starts at frame 1, and only that word.
- R10: One `inv_crc_req` pulse, given outside a CRC window, inverts the four CRC bits of the next half that starts after it, and only that half.
- R11: After reset, `dout`, `dout_vld` and `mf_mark` are 0, and the first bit accepted is bit 0 of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Strobe: one stream bit is accepted |
| din | input | 1 | Stream bit from the basic framer |
| febe_en | input | 1 | E bits report receive CRC errors |
| si_dis | input | 1 | E bits left untouched when error reporting is off |
| si_val | input | 2 | Static E values: [1] for E1, [0] for E2 |
| rx_err_smf1 | input | 1 | Receive CRC error pulse for half I |
| rx_err_smf2 | input | 1 | Receive CRC error pulse for half II |
| inv_align_req | input | 1 | Request one inverted alignment word |
| inv_crc_req | input | 1 | Request one inverted set of CRC bits |
| dout | output | 1 | Output stream bit |
| dout_vld | output | 1 | `dout` holds a new bit |
| mf_mark | output | 1 | Output bit is the first bit of the multiframe |

## Verification
The bench builds the block with BITS_PER_FRAME=16. A multiframe is then 256 bits, so the bench can run ten or more multiframes quickly. These runs cover CRC wrap between halves, the first-half all-ones rule, error events straddling E slots, and both one-shot inversions followed by a clean multiframe. The CRC logic and position decoding do not depend on frame length, so the short frame tests the same slot layout that 256-bit frames use.

// File: rtl/e1mf_pkg.sv
package e1mf_pkg;

    typedef enum logic [1:0] {
        SLOT_DATA,
        SLOT_ALIGN,
        SLOT_CRC,
        SLOT_EBIT
    } slot_e;

    typedef enum logic [1:0] {
        INJ_IDLE,
        INJ_ARMED,
        INJ_ACTIVE
    } inj_e;

    localparam int          FRAMES_PER_MF  = 16;
    localparam int          FRAMES_PER_SMF = 8;
    localparam int          FRAME_W        = $clog2(FRAMES_PER_MF);
    localparam logic [5:0]  ALIGN_WORD     = 6'b001011;
    localparam logic [2:0]  ALIGN_LAST_IDX = 3'd5;
    localparam logic [1:0]  CRC_LAST_IDX   = 2'd3;

    function automatic logic [3:0] crc4_next(input logic [3:0] cur, input logic b);
        logic fb;
        fb = b ^ cur[3];
        return {cur[2:0], 1'b0} ^ {2'b00, fb, fb};
    endfunction

endpackage

// File: rtl/e1mf_position.sv
module e1mf_position
    import e1mf_pkg::*;
#(
    parameter int BITS_PER_FRAME = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_en,
    output slot_e       kind,
    output logic [2:0]  idx,
    output logic        smf_last,
    output logic        mf_first
);

    localparam int            BW       = (BITS_PER_FRAME > 1) ? $clog2(BITS_PER_FRAME) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(BITS_PER_FRAME - 1);

    logic [BW-1:0]      bit_q;
    logic [FRAME_W-1:0] frame_q;
    logic               at_slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            frame_q <= '0;
        end else if (bit_en) begin
            if (bit_q == LAST_BIT) begin
                bit_q   <= '0;
                frame_q <= frame_q + 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    assign at_slot  = (bit_q == '0);
    assign smf_last = (bit_q == LAST_BIT) && (frame_q[2:0] == 3'd7);
    assign mf_first = at_slot && (frame_q == '0);

    always_comb begin
        kind = SLOT_DATA;
        idx  = 3'd0;
        if (at_slot) begin
            if (!frame_q[0]) begin
                kind = SLOT_CRC;
                idx  = {1'b0, frame_q[2:1]};
            end else if (frame_q < FRAME_W'(12)) begin
                kind = SLOT_ALIGN;
                idx  = frame_q[3:1];
            end else begin
                kind = SLOT_EBIT;
                idx  = {2'b00, frame_q[1]};
            end
        end
    end

    // R1: position frozen while no bit is accepted
    a_r1_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(bit_q) && $stable(frame_q)));

    // R1: a multiframe wraps back to frame 0
    a_r1_mf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_q == LAST_BIT && frame_q == '1) |=> mf_first);

endmodule

// File: rtl/e1mf_crc4.sv
module e1mf_crc4
    import e1mf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       feed,
    input  logic       smf_end,
    output logic [3:0] snap,
    output logic       snap_valid
);

    logic [3:0] run_q;
    logic [3:0] run_d;

    assign run_d = crc4_next(run_q, feed);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= '0;
            snap       <= '0;
            snap_valid <= 1'b0;
        end else if (bit_en) begin
            if (smf_end) begin
                run_q      <= '0;
                snap       <= run_d;
                snap_valid <= 1'b1;
            end else begin
                run_q <= run_d;
            end
        end
    end

    // R4: once a half is complete, the CRC result stays valid
    a_r4_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        snap_valid |=> snap_valid);

    // R3: the held CRC changes only at the end of a half
    a_r3_snap_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_en && smf_end) |=> $stable(snap));

endmodule

// File: rtl/e1mf_inject.sv
module e1mf_inject
    import e1mf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic win_start,
    input  logic win_stop,
    output logic invert
);

    inj_e state_q;
    inj_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= INJ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        invert  = 1'b0;
        unique case (state_q)
            INJ_IDLE: begin
                if (req) state_d = INJ_ARMED;
            end
            INJ_ARMED: begin
                if (win_start) begin
                    invert  = 1'b1;
                    state_d = INJ_ACTIVE;
                end
            end
            INJ_ACTIVE: begin
                invert = 1'b1;
                if (win_stop) state_d = INJ_IDLE;
            end
            default: state_d = INJ_IDLE;
        endcase
    end

    // R9, R10: a window is only inverted after an armed request
    a_r9_r10_enter_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d == INJ_ACTIVE && state_q != INJ_ACTIVE) |-> (state_q == INJ_ARMED));

    // R9, R10: the window ends and the controller returns to idle
    a_r9_r10_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == INJ_ACTIVE && win_stop) |=> (state_q == INJ_IDLE));

endmodule

// File: rtl/e1mf_ebits.sv
module e1mf_ebits (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] err_evt,
    input  logic [1:0] slot_hit,
    output logic [1:0] pend
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~slot_hit) | err_evt;
    end

    // R6: an event is remembered
    a_r6_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt[0] |=> pend[0]);

    // R6: a pending event survives until its slot
    a_r6_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[1] && !slot_hit[1]) |=> pend[1]);

endmodule

// File: rtl/e1_crc4_mfgen.sv
module e1_crc4_mfgen
    import e1mf_pkg::*;
#(
    parameter int BITS_PER_FRAME = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       din,
    input  logic       febe_en,
    input  logic       si_dis,
    input  logic [1:0] si_val,
    input  logic       rx_err_smf1,
    input  logic       rx_err_smf2,
    input  logic       inv_align_req,
    input  logic       inv_crc_req,
    output logic       dout,
    output logic       dout_vld,
    output logic       mf_mark
);

    slot_e      kind;
    logic [2:0] idx;
    logic       smf_last;
    logic       mf_first;
    logic [3:0] crc_snap;
    logic       crc_valid;
    logic       align_inv;
    logic       crc_inv;
    logic [1:0] e_pend;
    logic [1:0] e_hit;
    logic       tx_bit;
    logic       crc_feed;
    logic       crc_raw;
    logic       e_sel;
    logic       e_val;

    e1mf_position #(.BITS_PER_FRAME(BITS_PER_FRAME)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .kind     (kind),
        .idx      (idx),
        .smf_last (smf_last),
        .mf_first (mf_first)
    );

    e1mf_crc4 u_crc (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .feed       (crc_feed),
        .smf_end    (smf_last),
        .snap       (crc_snap),
        .snap_valid (crc_valid)
    );

    e1mf_inject u_inj_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (inv_align_req),
        .win_start (bit_en && kind == SLOT_ALIGN && idx == 3'd0),
        .win_stop  (bit_en && kind == SLOT_ALIGN && idx == ALIGN_LAST_IDX),
        .invert    (align_inv)
    );

    e1mf_inject u_inj_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (inv_crc_req),
        .win_start (bit_en && kind == SLOT_CRC && idx[1:0] == 2'd0),
        .win_stop  (bit_en && kind == SLOT_CRC && idx[1:0] == CRC_LAST_IDX),
        .invert    (crc_inv)
    );

    assign e_sel = idx[0];
    assign e_hit = {bit_en && kind == SLOT_EBIT && e_sel,
                    bit_en && kind == SLOT_EBIT && !e_sel};

    e1mf_ebits u_ebits (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_evt  ({rx_err_smf2, rx_err_smf1}),
        .slot_hit (e_hit),
        .pend     (e_pend)
    );

    always_comb begin
        if (febe_en)      e_val = e_sel ? ~e_pend[1] : ~e_pend[0];
        else if (!si_dis) e_val = e_sel ? si_val[0] : si_val[1];
        else              e_val = din;
    end

    assign crc_raw = crc_valid ? crc_snap[2'd3 - idx[1:0]] : 1'b1;

    always_comb begin
        tx_bit   = din;
        crc_feed = din;
        unique case (kind)
            SLOT_DATA: begin
                tx_bit   = din;
                crc_feed = din;
            end
            SLOT_ALIGN: begin
                tx_bit   = ALIGN_WORD[ALIGN_LAST_IDX - idx] ^ align_inv;
                crc_feed = tx_bit;
            end
            SLOT_CRC: begin
                tx_bit   = crc_raw ^ crc_inv;
                crc_feed = 1'b0;
            end
            SLOT_EBIT: begin
                tx_bit   = e_val;
                crc_feed = e_val;
            end
            default: begin
                tx_bit   = din;
                crc_feed = din;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout     <= 1'b0;
            dout_vld <= 1'b0;
            mf_mark  <= 1'b0;
        end else begin
            dout_vld <= bit_en;
            mf_mark  <= bit_en && mf_first;
            if (bit_en) dout <= tx_bit;
        end
    end

    // R1: output valid follows the strobe by one clock
    a_r1_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> dout_vld);

    a_r1_vld_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> !dout_vld);

    // R1: the multiframe mark only accompanies a valid bit
    a_r1_mark_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
        mf_mark |-> dout_vld);

    // R11: the output bit is stable when no bit is accepted
    a_r11_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(dout));

endmodule

// File: tb/tb_e1_crc4_mfgen.sv
module tb_e1_crc4_mfgen;

    localparam int CLK_PERIOD = 10;
    localparam int BPF        = 16;
    localparam int MF_BITS    = BPF * 16;
    localparam logic [5:0] WORD = 6'b001011;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       din = 1'b0;
    logic       febe_en = 1'b0;
    logic       si_dis = 1'b0;
    logic [1:0] si_val = 2'b00;
    logic       rx_err_smf1 = 1'b0;
    logic       rx_err_smf2 = 1'b0;
    logic       inv_align_req = 1'b0;
    logic       inv_crc_req = 1'b0;
    logic       dout;
    logic       dout_vld;
    logic       mf_mark;

    int tests = 0;
    int fails = 0;

    // bench model state
    int         b_bit = 0;
    int         b_frame = 0;
    logic [3:0] m_run = 4'h0;
    logic [3:0] m_snap = 4'h0;
    logic       m_valid = 1'b0;
    logic [1:0] m_pend = 2'b00;
    logic       pa = 1'b0, ai = 1'b0, pc = 1'b0, ci = 1'b0;
    int         mode = 1;
    int         align_flips = 0;
    int         crc_flips = 0;
    int         ez0 = 0, ez1 = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic       s_e1 = 0, s_e2 = 0, s_ra = 0, s_rc = 0;

    e1_crc4_mfgen #(.BITS_PER_FRAME(BPF)) dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(din),
        .febe_en(febe_en), .si_dis(si_dis), .si_val(si_val),
        .rx_err_smf1(rx_err_smf1), .rx_err_smf2(rx_err_smf2),
        .inv_align_req(inv_align_req), .inv_crc_req(inv_crc_req),
        .dout(dout), .dout_vld(dout_vld), .mf_mark(mf_mark)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] crc_step(input logic [3:0] c, input logic b);
        logic fb;
        fb = b ^ c[3];
        return {c[2:0], 1'b0} ^ {2'b00, fb, fb};
    endfunction

    task automatic chk(input logic ok, input string req, input logic act, input logic exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b (frame %0d bit %0d)", req, act, exp, b_frame, b_bit);
        end
    endtask

    task automatic set_mode(input int m);
        mode = m;
        febe_en = (m == 0);
        si_dis  = (m == 2);
    endtask

    task automatic step(input logic en);
        logic d;
        logic e;
        logic exp;
        int   ix;
        d = lfsr[0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        @(negedge clk);
        bit_en = en; din = d;
        rx_err_smf1 = s_e1; rx_err_smf2 = s_e2;
        inv_align_req = s_ra; inv_crc_req = s_rc;
        @(posedge clk);
        #1;
        bit_en = 0; rx_err_smf1 = 0; rx_err_smf2 = 0;
        inv_align_req = 0; inv_crc_req = 0;
        if (!en) begin
            chk(dout_vld == 1'b0, "R1 vld low on idle", dout_vld, 1'b0);
        end else begin
            chk(dout_vld == 1'b1, "R1 vld", dout_vld, 1'b1);
            chk(mf_mark == (b_bit == 0 && b_frame == 0), "R1 mf_mark", mf_mark, (b_bit == 0 && b_frame == 0));
            if (b_bit != 0) begin
                chk(dout == d, "R1 pass-through", dout, d);
            end else if (b_frame % 2 == 0) begin
                ix = (b_frame % 8) / 2;
                if (ix == 0 && pc) begin ci = 1; pc = 0; end
                exp = (m_valid ? m_snap[3 - ix] : 1'b1) ^ ci;
                if (m_valid && dout != m_snap[3 - ix]) crc_flips++;
                chk(dout == exp, ci ? "R10 crc inversion" : (m_valid ? "R3 crc bit" : "R4 crc ones"), dout, exp);
                if (ix == 3) ci = 0;
            end else if (b_frame < 12) begin
                ix = b_frame / 2;
                if (ix == 0 && pa) begin ai = 1; pa = 0; end
                exp = WORD[5 - ix] ^ ai;
                if (dout != WORD[5 - ix]) align_flips++;
                chk(dout == exp, ai ? "R9 align inversion" : "R2 align word", dout, exp);
                if (ix == 5) ai = 0;
            end else begin
                e = (b_frame == 15);
                if (mode == 0) begin
                    exp = ~m_pend[e];
                    if (dout == 1'b0) begin if (e) ez1++; else ez0++; end
                    chk(dout == exp, e ? "R6 R5 E2 error report" : "R6 R5 E1 error report", dout, exp);
                end else if (mode == 1) begin
                    exp = e ? si_val[0] : si_val[1];
                    chk(dout == exp, "R7 R5 static E bit", dout, exp);
                end else begin
                    exp = d;
                    chk(dout == exp, "R8 E pass-through", dout, exp);
                end
                m_pend[e] = 1'b0;
            end
            m_run = crc_step(m_run, (b_bit == 0 && b_frame % 2 == 0) ? 1'b0 : dout);
            if (b_bit == BPF - 1 && b_frame % 8 == 7) begin
                m_snap = m_run; m_valid = 1; m_run = 4'h0;
            end
            b_bit++;
            if (b_bit == BPF) begin b_bit = 0; b_frame = (b_frame + 1) % 16; end
        end
        if (s_e1) m_pend[0] = 1'b1;
        if (s_e2) m_pend[1] = 1'b1;
        if (s_ra) pa = 1;
        if (s_rc) pc = 1;
        s_e1 = 0; s_e2 = 0; s_ra = 0; s_rc = 0;
    endtask

    task automatic run_bits(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic run_until(input int f, input int b);
        while (!(b_frame == f && b_bit == b)) step(1'b1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(dout == 1'b0, "R11 dout reset", dout, 1'b0);
        chk(dout_vld == 1'b0, "R11 vld reset", dout_vld, 1'b0);
        chk(mf_mark == 1'b0, "R11 mark reset", mf_mark, 1'b0);
    endtask

    task automatic t_static_e;
        set_mode(1);
        si_val = 2'b10;
        run_bits(2 * MF_BITS);
        si_val = 2'b01;
        run_bits(MF_BITS);
    endtask

    task automatic t_far_end;
        set_mode(0);
        run_until(0, 0);
        run_bits(MF_BITS);
        ez0 = 0; ez1 = 0;
        for (int i = 0; i < 2 * MF_BITS; i++) begin
            s_e1 = (i < MF_BITS && b_frame == 3 && b_bit == 5);
            s_e2 = (i < MF_BITS && b_frame == 15 && b_bit == 0);
            step(1'b1);
        end
        chk(ez0 == 1, "R6 E1 zero count", ez0 == 1, 1'b1);
        chk(ez1 == 1, "R6 E2 zero count (slot-cycle event deferred)", ez1 == 1, 1'b1);
    endtask

    task automatic t_passthrough;
        set_mode(2);
        run_bits(MF_BITS);
    endtask

    task automatic t_stall;
        set_mode(1);
        for (int i = 0; i < MF_BITS; i++) begin
            step(1'b0);
            step(1'b1);
        end
    endtask

    task automatic t_align_inv;
        set_mode(1);
        run_until(13, 3);
        align_flips = 0;
        s_ra = 1;
        step(1'b1);
        run_bits(2 * MF_BITS);
        chk(align_flips == 6, "R9 exactly one word inverted", align_flips == 6, 1'b1);
    endtask

    task automatic t_crc_inv;
        set_mode(1);
        run_until(9, 2);
        crc_flips = 0;
        s_rc = 1;
        step(1'b1);
        run_bits(2 * MF_BITS);
        chk(crc_flips == 4, "R10 exactly four CRC bits inverted", crc_flips == 4, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        set_mode(1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_static_e();
        t_far_end();
        t_passthrough();
        t_stall();
        t_align_inv();
        t_crc_inv();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule